// File: doc/BRIEF.md
# Serial Port Register Front End

This block is the word-wide register face of a simple serial port. Software sees a small map of 32-bit registers: transmit and receive control words, a data-out word, two status/data words that return the oldest received byte, and an interrupt group made of a raw view, a mask, an acknowledge word and a masked view. Received bytes come in from the line side on a valid/ready byte port and wait in a 16-entry ring buffer. A write to the data-out word sends its low byte to the line side as a one-cycle strobe. The transmitter is treated as always ready and idle.

The two status/data words differ in one way. One of them only reads the oldest byte. The other also removes that byte from the buffer. A received-data interrupt bit follows the buffer occupancy. The two transmit interrupt bits are set by every data-out write. The first acknowledge after a transmit leaves the transmit-done bit (bit 0) set. The interrupt line is high whenever the masked view is non-zero.

Byte offsets are decoded from bits 5:2 of `bus_addr`. Only one access is made per cycle. When `bus_wr` is high, `bus_rd` is ignored. Read data is combinational in the cycle of the read. State changes take effect at the next rising edge. `rst_n` is asynchronous and active-low, and is expected to be released in step with `clk`.

Top module: `serial_reg_front`

## Requirements
- R1: After reset, the receive control word (offset 0x08) reads 0x00010000, `rx_ready`, `irq` and `tx_valid` are low, and a status read returns 0x01400000 in bits 31:8.
- R2: `rx_ready` is high exactly when bit 3 of the receive control word is 1 and fewer than 16 bytes are held. A byte is taken on a rising edge where `rx_valid` and `rx_ready` are both high.
- R3: The buffer returns bytes in arrival order and holds at most 16. While it is full, a byte offered on the port is not stored and does not change later reads.
- R4: A read at offset 0x20 or 0x24 returns the oldest held byte in bits 7:0. Bit 16 is 1 when the buffer is not empty. Bits 22 and 24 are always 1. All other bits are 0.
- R5: A read at 0x24 leaves the buffer unchanged. A read at 0x20 removes one byte when the buffer is not empty, and has no effect when it is empty.
- R6: The raw interrupt word (offset 0x34) has bit 3 set exactly while the buffer holds at least one byte.
- R7: A write to offset 0x1C stores the value there (it reads back unchanged). It drives `tx_valid` high for exactly the next cycle, with `tx_data` equal to the written bits 7:0. It also sets raw interrupt bits 0 and 1.
- R8: A write to the acknowledge word (offset 0x30) clears every raw interrupt bit that is 1 in the written value. The exception is the first acknowledge after a data-out write: bit 0 is removed from that value before use, so bit 0 stays set. The value actually used is what reads back from 0x30.
- R9: The masked word (offset 0x38) equals raw AND the mask word (offset 0x2C). `irq` is high exactly when that word is non-zero, from the cycle after the event that changed it.
- R10: Writes to offsets other than 0x20, 0x24, 0x34, 0x38 and 0x3C store the value, which then reads back. Writes to those five offsets change nothing, and a read at 0x3C returns 0.
- R11: When a removing read and an accepted byte arrive in the same cycle, both take effect: occupancy is unchanged and the new byte lands behind the remaining ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Word write strobe |
| bus_rd | input | 1 | Word read strobe |
| bus_addr | input | 6 | Byte offset; bits 1:0 ignored |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the read cycle |
| rx_valid | input | 1 | Line side offers a received byte |
| rx_data | input | 8 | Received byte |
| rx_ready | output | 1 | Buffer enabled and has room |
| tx_valid | output | 1 | One-cycle transmit byte strobe |
| tx_data | output | 8 | Transmit byte |
| irq | output | 1 | Level interrupt |

## Verification
Errors in the occupancy count or the write pointer show up at the ports in three places: the status word in the very next read (wrong byte, or a wrong data-available bit), `rx_ready` staying high when the buffer is full, and raw bit 3 or `irq` disagreeing with the buffer contents one cycle after a push or removal. If the pending-transmit flag is wrong, the next acknowledge clears or keeps bit 0 incorrectly. That shows up in the raw and acknowledge readbacks and on `irq` in the following cycle. Random mixes of pushes, removing reads, peeks, same-cycle push-and-remove, and interrupt writes are compared read by read against a bench model. Directed steps add the full buffer, the empty buffer, and the double acknowledge.

// File: rtl/sreg_pkg.sv
package sreg_pkg;
  localparam int unsigned WORD_W  = 32;
  localparam int unsigned BYTE_W  = 8;
  localparam int unsigned ADDR_W  = 6;
  localparam int unsigned IX_W    = ADDR_W - 2;
  localparam int unsigned NWORDS  = 15;
  localparam int unsigned RX_DEPTH = 16;

  localparam logic [IX_W-1:0] IX_TX_CTRL  = 4'd0;
  localparam logic [IX_W-1:0] IX_DMA_EN   = 4'd1;
  localparam logic [IX_W-1:0] IX_RX_CTRL  = 4'd2;
  localparam logic [IX_W-1:0] IX_DOUT     = 4'd7;
  localparam logic [IX_W-1:0] IX_ST_POP   = 4'd8;
  localparam logic [IX_W-1:0] IX_ST_PEEK  = 4'd9;
  localparam logic [IX_W-1:0] IX_MASK     = 4'd11;
  localparam logic [IX_W-1:0] IX_ACK      = 4'd12;
  localparam logic [IX_W-1:0] IX_RAW      = 4'd13;
  localparam logic [IX_W-1:0] IX_MASKED   = 4'd14;

  localparam int unsigned BIT_DAV    = 16;
  localparam int unsigned BIT_TIDLE  = 22;
  localparam int unsigned BIT_TRDY   = 24;
  localparam int unsigned BIT_RX_EN  = 3;
  localparam int unsigned BIT_IR_RX  = 3;

  localparam logic [WORD_W-1:0] RX_CTRL_RST = 32'h0001_0000;

  function automatic logic is_derived(input int unsigned ix);
    return (ix == 8) || (ix == 9) || (ix == 13) || (ix == 14);
  endfunction
endpackage

// File: rtl/sr_rx_fifo.sv
module sr_rx_fifo #(
  parameter int unsigned DEPTH = 16,
  parameter int unsigned DW    = 8,
  localparam int unsigned PW   = $clog2(DEPTH),
  localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [DW-1:0] push_data,
  input  logic          pop,
  output logic [DW-1:0] head_data,
  output logic [CW-1:0] occ,
  output logic          full,
  output logic          nonempty
);
  logic [DW-1:0] mem [DEPTH];
  logic [CW-1:0] occ_q, occ_n;
  logic [PW-1:0] wp_q, wp_n;
  logic [PW-1:0] head_ix;
  logic          do_push, do_pop;

  assign full     = (occ_q == CW'(DEPTH));
  assign nonempty = (occ_q != '0);
  assign do_push  = push && !full;
  assign do_pop   = pop && nonempty;
  assign head_ix  = wp_q - occ_q[PW-1:0];
  assign head_data = mem[head_ix];
  assign occ      = occ_q;

  always_comb begin
    occ_n = occ_q;
    wp_n  = wp_q;
    if (do_push) begin
      wp_n  = wp_q + PW'(1);
      occ_n = occ_n + CW'(1);
    end
    if (do_pop) begin
      occ_n = occ_n - CW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      occ_q <= '0;
      wp_q  <= '0;
    end else begin
      occ_q <= occ_n;
      wp_q  <= wp_n;
    end
  end

  always_ff @(posedge clk) begin
    if (do_push) begin
      mem[wp_q] <= push_data;
    end
  end
endmodule

// File: rtl/sr_word_bank.sv
module sr_word_bank #(
  parameter int unsigned NW       = 15,
  parameter int unsigned W        = 32,
  parameter int unsigned IXW      = 4,
  parameter int unsigned RST_IX   = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic [IXW-1:0]       wr_ix,
  input  logic [W-1:0]         wr_data,
  output logic [NW-1:0][W-1:0] words
);
  for (genvar g = 0; g < NW; g++) begin : g_word
    if (sreg_pkg::is_derived(g)) begin : g_none
      assign words[g] = '0;
    end else begin : g_store
      localparam logic [W-1:0] RV = (g == RST_IX) ? RST_VAL : '0;
      logic          hit;
      logic [W-1:0]  word_q, word_n;
      assign hit = wr_en && (wr_ix == IXW'(g));
      always_comb begin
        word_n = word_q;
        if (hit) word_n = wr_data;
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) word_q <= RV;
        else        word_q <= word_n;
      end
      assign words[g] = word_q;
    end
  end
endmodule

// File: rtl/sr_irq_unit.sv
module sr_irq_unit #(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         dout_wr,
  input  logic         ack_wr,
  input  logic [W-1:0] ack_val,
  input  logic [W-1:0] mask,
  input  logic         rx_nonempty,
  output logic [W-1:0] ack_used,
  output logic [W-1:0] raw_view,
  output logic [W-1:0] masked_view,
  output logic         irq
);
  logic [W-1:0] raw_q, raw_n;
  logic         pend_q, pend_n;

  always_comb begin
    raw_n    = raw_q;
    pend_n   = pend_q;
    ack_used = ack_val;
    if (ack_wr) begin
      if (pend_q) begin
        ack_used[0] = 1'b0;
        pend_n      = 1'b0;
      end
      raw_n = raw_n & ~ack_used;
    end
    if (dout_wr) begin
      raw_n  = raw_n | W'(3);
      pend_n = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      raw_q  <= '0;
      pend_q <= 1'b0;
    end else begin
      raw_q  <= raw_n;
      pend_q <= pend_n;
    end
  end

  always_comb begin
    raw_view = raw_q;
    raw_view[sreg_pkg::BIT_IR_RX] = rx_nonempty;
  end
  assign masked_view = raw_view & mask;
  assign irq         = |masked_view;
endmodule

// File: rtl/serial_reg_front.sv
module serial_reg_front
  import sreg_pkg::*;
#(
  parameter int unsigned DEPTH = RX_DEPTH,
  localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [WORD_W-1:0] bus_wdata,
  output logic [WORD_W-1:0] bus_rdata,
  input  logic              rx_valid,
  input  logic [BYTE_W-1:0] rx_data,
  output logic              rx_ready,
  output logic              tx_valid,
  output logic [BYTE_W-1:0] tx_data
  ,output logic             irq
);
  logic [IX_W-1:0]              ix;
  logic [NWORDS-1:0][WORD_W-1:0] words;
  logic [WORD_W-1:0]            bank_wdata, ack_used, raw_view, masked_view, status;
  logic [BYTE_W-1:0]            head;
  logic [CW-1:0]                occ;
  logic                         full, nonempty, rx_en, rx_accept, pop_req;
  logic                         dout_wr, ack_wr;
  logic                         txv_q, txv_n;
  logic [BYTE_W-1:0]            txd_q, txd_n;

  assign ix        = bus_addr[ADDR_W-1:2];
  assign rx_en     = words[IX_RX_CTRL][BIT_RX_EN];
  assign rx_ready  = rx_en && !full;
  assign rx_accept = rx_valid && rx_ready;
  assign pop_req   = bus_rd && !bus_wr && (ix == IX_ST_POP);
  assign dout_wr   = bus_wr && (ix == IX_DOUT);
  assign ack_wr    = bus_wr && (ix == IX_ACK);

  sr_rx_fifo #(.DEPTH(DEPTH), .DW(BYTE_W)) u_fifo (
    .clk(clk), .rst_n(rst_n),
    .push(rx_accept), .push_data(rx_data), .pop(pop_req),
    .head_data(head), .occ(occ), .full(full), .nonempty(nonempty)
  );

  assign bank_wdata = ack_wr ? ack_used : bus_wdata;

  sr_word_bank #(
    .NW(NWORDS), .W(WORD_W), .IXW(IX_W),
    .RST_IX(int'(IX_RX_CTRL)), .RST_VAL(RX_CTRL_RST)
  ) u_bank (
    .clk(clk), .rst_n(rst_n),
    .wr_en(bus_wr && (int'(ix) < NWORDS)), .wr_ix(ix), .wr_data(bank_wdata),
    .words(words)
  );

  sr_irq_unit #(.W(WORD_W)) u_irq (
    .clk(clk), .rst_n(rst_n),
    .dout_wr(dout_wr), .ack_wr(ack_wr), .ack_val(bus_wdata),
    .mask(words[IX_MASK]), .rx_nonempty(nonempty),
    .ack_used(ack_used), .raw_view(raw_view), .masked_view(masked_view),
    .irq(irq)
  );

  always_comb begin
    status = '0;
    status[BYTE_W-1:0] = head;
    status[BIT_DAV]    = nonempty;
    status[BIT_TIDLE]  = 1'b1;
    status[BIT_TRDY]   = 1'b1;
  end

  always_comb begin
    case (ix)
      IX_ST_POP, IX_ST_PEEK: bus_rdata = status;
      IX_RAW:                bus_rdata = raw_view;
      IX_MASKED:             bus_rdata = masked_view;
      default: begin
        if (int'(ix) < NWORDS) bus_rdata = words[ix];
        else                   bus_rdata = '0;
      end
    endcase
  end

  always_comb begin
    txv_n = dout_wr;
    txd_n = txd_q;
    if (dout_wr) txd_n = bus_wdata[BYTE_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      txv_q <= 1'b0;
      txd_q <= '0;
    end else begin
      txv_q <= txv_n;
      txd_q <= txd_n;
    end
  end

  assign tx_valid = txv_q;
  assign tx_data  = txd_q;
endmodule

// File: rtl/serial_reg_front_chk.sv
module serial_reg_front_chk
  import sreg_pkg::*;
#(
  parameter int unsigned DEPTH = RX_DEPTH,
  localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_wr,
  input logic              bus_rd,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [WORD_W-1:0] bus_wdata,
  input logic [WORD_W-1:0] bus_rdata,
  input logic              rx_ready,
  input logic              rx_accept,
  input logic              rx_en,
  input logic [CW-1:0]     occ,
  input logic              tx_valid,
  input logic [BYTE_W-1:0] tx_data
);
  logic [IX_W-1:0] ix;
  logic            is_stat;
  assign ix      = bus_addr[ADDR_W-1:2];
  assign is_stat = bus_rd && !bus_wr && ((ix == IX_ST_POP) || (ix == IX_ST_PEEK));

  // R3
  a_r3_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    occ <= CW'(DEPTH));

  // R2
  a_r2_ready_rule: assert property (@(posedge clk) disable iff (!rst_n)
    rx_ready |-> (rx_en && (occ < CW'(DEPTH))));

  // R4
  a_r4_status_bits: assert property (@(posedge clk) disable iff (!rst_n)
    is_stat |-> (bus_rdata[BIT_TRDY] && bus_rdata[BIT_TIDLE]
                 && (bus_rdata[BIT_DAV] == (occ != '0))
                 && (bus_rdata[31:25] == '0) && (bus_rdata[23] == 1'b0)
                 && (bus_rdata[21:17] == '0) && (bus_rdata[15:8] == '0)));

  // R5
  a_r5_peek_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && !bus_wr && (ix == IX_ST_PEEK) && !rx_accept) |=> (occ == $past(occ)));

  // R5
  a_r5_pop_takes: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && !bus_wr && (ix == IX_ST_POP) && (occ != '0) && !rx_accept)
      |=> (occ == $past(occ) - CW'(1)));

  // R11
  a_r11_push_pop: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && !bus_wr && (ix == IX_ST_POP) && (occ != '0) && rx_accept)
      |=> (occ == $past(occ)));

  // R7
  a_r7_tx_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && (ix == IX_DOUT)) |=> (tx_valid && (tx_data == $past(bus_wdata[BYTE_W-1:0]))));

  // R7
  a_r7_tx_cause: assert property (@(posedge clk) disable iff (!rst_n)
    (!(bus_wr && (ix == IX_DOUT))) |=> !tx_valid);
endmodule

bind serial_reg_front serial_reg_front_chk #(.DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
  .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
  .rx_ready(rx_ready), .rx_accept(rx_accept), .rx_en(rx_en), .occ(occ),
  .tx_valid(tx_valid), .tx_data(tx_data)
);

// File: tb/serial_reg_front_tb.sv
`timescale 1ns/1ps
module serial_reg_front_tb;
  logic        clk, rst_n;
  logic        bus_wr, bus_rd;
  logic [5:0]  bus_addr;
  logic [31:0] bus_wdata, bus_rdata;
  logic        rx_valid, rx_ready, tx_valid, irq;
  logic [7:0]  rx_data, tx_data;

  serial_reg_front u_dut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .rx_valid(rx_valid), .rx_data(rx_data), .rx_ready(rx_ready),
    .tx_valid(tx_valid), .tx_data(tx_data), .irq(irq)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  int checks = 0, fails = 0;
  bit done = 0;

  // bench model
  logic [7:0]  m_buf [16];
  int          m_wp, m_cnt;
  logic [31:0] m_regs [15];
  logic [31:0] m_raw;
  bit          m_pend;

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic bit derived(int ix);
    return ix == 8 || ix == 9 || ix == 13 || ix == 14;
  endfunction
  function automatic bit m_ready();
    return m_regs[2][3] && (m_cnt < 16);
  endfunction
  function automatic logic [31:0] m_rawv();
    logic [31:0] r = m_raw;
    r[3] = (m_cnt != 0);
    return r;
  endfunction
  function automatic logic [31:0] m_status();
    logic [31:0] s = 32'h0140_0000;
    s[7:0] = m_buf[(m_wp - m_cnt) & 15];
    s[16]  = (m_cnt != 0);
    return s;
  endfunction
  function automatic logic [31:0] m_read(int ix);
    if (ix == 8 || ix == 9) return m_status();
    if (ix == 13) return m_rawv();
    if (ix == 14) return m_rawv() & m_regs[11];
    if (ix == 15) return 32'h0;
    return m_regs[ix];
  endfunction

  task automatic post_checks(bit tx_exp, logic [7:0] txd_exp);
    chk("R7 tx_valid", {31'b0, tx_valid}, {31'b0, tx_exp});
    if (tx_exp) chk("R7 tx_data", {24'b0, tx_data}, {24'b0, txd_exp});
    chk("R9 irq", {31'b0, irq}, {31'b0, |(m_rawv() & m_regs[11])});
    chk("R2 rx_ready", {31'b0, rx_ready}, {31'b0, m_ready()});
  endtask

  task automatic t_write(logic [5:0] a, logic [31:0] d);
    int ix = int'(a[5:2]);
    logic [31:0] adj;
    bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(posedge clk); #1;
    bus_wr = 0;
    if (ix < 15 && !derived(ix)) begin
      if (ix == 12) begin
        adj = d;
        if (m_pend) begin adj[0] = 1'b0; m_pend = 0; end
        m_raw &= ~adj;
        m_regs[12] = adj;
      end else begin
        m_regs[ix] = d;
        if (ix == 7) begin m_raw |= 32'h3; m_pend = 1; end
      end
    end
    post_checks(ix == 7, d[7:0]);
  endtask

  // read, optionally with a byte offered in the same cycle
  task automatic t_read(logic [5:0] a, bit push, logic [7:0] pd, string req);
    int ix = int'(a[5:2]);
    logic [31:0] e, msk;
    bit acc, pop;
    bus_rd = 1; bus_addr = a; rx_valid = push; rx_data = pd;
    #1;
    e = m_read(ix);
    msk = ((ix == 8 || ix == 9) && m_cnt == 0) ? 32'hFFFF_FF00 : 32'hFFFF_FFFF;
    chk(req, bus_rdata & msk, e & msk);
    acc = push && m_ready();
    pop = (ix == 8) && (m_cnt != 0);
    @(posedge clk); #1;
    bus_rd = 0; rx_valid = 0;
    if (pop) m_cnt--;
    if (acc) begin m_buf[m_wp] = pd; m_wp = (m_wp + 1) & 15; m_cnt++; end
    post_checks(0, 8'h0);
  endtask

  task automatic t_push(logic [7:0] pd);
    bit acc;
    rx_valid = 1; rx_data = pd;
    #1;
    chk("R2 ready before push", {31'b0, rx_ready}, {31'b0, m_ready()});
    acc = m_ready();
    @(posedge clk); #1;
    rx_valid = 0;
    if (acc) begin m_buf[m_wp] = pd; m_wp = (m_wp + 1) & 15; m_cnt++; end
    post_checks(0, 8'h0);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [5:0] addrs [12];
    void'($urandom(32'd1234));
    bus_wr = 0; bus_rd = 0; bus_addr = 0; bus_wdata = 0;
    rx_valid = 0; rx_data = 0;
    m_wp = 0; m_cnt = 0; m_raw = 0; m_pend = 0;
    for (int i = 0; i < 15; i++) m_regs[i] = 32'h0;
    for (int i = 0; i < 16; i++) m_buf[i] = 8'h0;
    m_regs[2] = 32'h0001_0000;
    rst_n = 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(posedge clk); #1;

    // R1 reset state
    chk("R1 rx_ready", {31'b0, rx_ready}, 32'h0);
    chk("R1 irq", {31'b0, irq}, 32'h0);
    chk("R1 tx_valid", {31'b0, tx_valid}, 32'h0);
    t_read(6'h08, 0, 8'h0, "R1 rx ctrl reset");
    t_read(6'h24, 0, 8'h0, "R1 status reset");

    // R2 disabled receiver refuses bytes
    t_push(8'hA5);
    t_read(6'h24, 0, 8'h0, "R2 nothing taken while disabled");

    // enable receiver, fill to full (R3)
    t_write(6'h08, 32'h0001_0008);
    for (int i = 0; i < 16; i++) t_push(8'h10 + 8'(i));
    chk("R3 full no ready", {31'b0, rx_ready}, 32'h0);
    t_push(8'hEE);
    t_read(6'h24, 0, 8'h0, "R5 peek head");
    t_read(6'h24, 0, 8'h0, "R5 peek again same");
    t_read(6'h34, 0, 8'h0, "R6 raw bit3 while held");
    for (int i = 0; i < 16; i++) t_read(6'h20, 0, 8'h0, "R3 order on pop");
    t_read(6'h20, 0, 8'h0, "R5 pop on empty");
    t_read(6'h34, 0, 8'h0, "R6 raw bit3 empty");

    // R11 same-cycle pop and push
    t_push(8'h41); t_push(8'h42);
    t_read(6'h20, 1, 8'h43, "R11 pop with push");
    t_read(6'h24, 0, 8'h0, "R11 head after");
    t_read(6'h20, 0, 8'h0, "R11 pop 2");
    t_read(6'h20, 0, 8'h0, "R11 pop 3");
    t_read(6'h20, 1, 8'h44, "R11 empty pop with push");
    t_read(6'h24, 0, 8'h0, "R11 byte kept");

    // R7, R8 transmit and acknowledge
    t_write(6'h1C, 32'hCAFE_0137);
    t_read(6'h1C, 0, 8'h0, "R7 dout readback");
    t_read(6'h34, 0, 8'h0, "R7 raw after tx");
    t_write(6'h30, 32'h0000_0003);
    t_read(6'h30, 0, 8'h0, "R8 adjusted ack");
    t_read(6'h34, 0, 8'h0, "R8 bit0 kept");
    t_write(6'h30, 32'h0000_0001);
    t_read(6'h34, 0, 8'h0, "R8 bit0 cleared");

    // R9 mask and irq
    t_write(6'h2C, 32'h0000_0008);
    t_read(6'h38, 0, 8'h0, "R9 masked");
    t_write(6'h2C, 32'h0000_0001);
    t_write(6'h1C, 32'h0000_0055);
    t_read(6'h38, 0, 8'h0, "R9 masked tx");

    // R10 generic storage and ignored writes
    t_write(6'h10, 32'h1234_5678);
    t_read(6'h10, 0, 8'h0, "R10 generic readback");
    t_write(6'h34, 32'hFFFF_FFFF);
    t_read(6'h34, 0, 8'h0, "R10 raw write ignored");
    t_write(6'h20, 32'hFFFF_FFFF);
    t_read(6'h24, 0, 8'h0, "R10 status write ignored");
    t_write(6'h3C, 32'hFFFF_FFFF);
    t_read(6'h3C, 0, 8'h0, "R10 out of range zero");

    // random mix
    addrs = '{6'h00, 6'h04, 6'h08, 6'h1C, 6'h20, 6'h24, 6'h2C, 6'h30, 6'h34, 6'h38, 6'h14, 6'h28};
    for (int n = 0; n < 4000; n++) begin
      int k = int'($urandom_range(0, 9));
      case (k)
        0, 1, 2: t_push(8'($urandom));
        3: t_read(6'h20, bit'($urandom_range(0, 1)), 8'($urandom), "R5 rand pop");
        4: t_read(6'h24, bit'($urandom_range(0, 1)), 8'($urandom), "R4 rand peek");
        5: t_read(addrs[$urandom_range(0, 11)], 0, 8'h0, "R9 rand read");
        6: t_write(6'h1C, $urandom);
        7: t_write(6'h30, {28'h0, 4'($urandom)});
        8: t_write(6'h2C, {28'h0, 4'($urandom)});
        default: t_write(6'h08, {16'h0001, 12'h0, $urandom_range(0, 3) != 0, 3'b0});
      endcase
    end

    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule